// File: doc/BRIEF.md
# Bottleneck Waiting-Cycle Table

This block keeps a small associative table of serializing bottlenecks, such as contended locks, barriers and slow pipeline stages. Each bottleneck has a numeric identifier. The cores report when a thread starts or stops waiting on a bottleneck. For each identifier the table tracks how many threads are waiting right now. It also accumulates the total thread-waiting cycles, so a bottleneck that makes many threads wait for a long time ranks high.

When a small core is about to run a bottleneck, it presents a call. One cycle later the table answers with an update for that core's acceleration index. The update says whether the bottleneck should be shipped to a large core, and which large core. The answer is yes when the accumulated waiting cycles exceed a programmable threshold. A bottleneck that runs locally is remembered, together with the core running it. If that bottleneck then becomes the entry with the most waiting cycles, the table sends a one-cycle preemption pulse to that core. An optional epoch counter halves every waiting-cycle count at a fixed interval, so that old behaviour fades.

Top module: `bottleneck_wait_table`

## Requirements
- R1: After reset the table holds no entries and both output pulses are low. A call made before any wait event is answered with the local decision (accelerate bit 0).
- R2: A wait-start for an identifier not in the table creates an entry with one waiter and zero waiting cycles. A wait-start for a present identifier adds one waiter.
- R3: On every clock edge, each valid entry adds its current waiter count to its waiting-cycle count. The sum saturates at 2^TWC_W-1.
- R4: A wait-end for a present identifier removes one waiter. The count never goes below zero.
- R5: Allocation uses the lowest-numbered free entry. When the table is full, it replaces the entry with the smallest waiting-cycle count, and the lowest index wins a tie. A replaced identifier then reads as absent.
- R6: A call is answered on the next edge with the update valid bit, the calling core, the identifier, and the accelerate bit. The accelerate bit is 1 only when the identifier is present and its waiting-cycle count at the call edge is strictly greater than the threshold. The update also carries the large-core number, which is the identifier modulo N_LARGE.
- R7: A call answered locally marks the entry as running on the calling core. A return for that identifier, or an accelerated call, clears the mark.
- R8: When the valid entry with the highest waiting-cycle count is marked running and its count is nonzero, the table pulses the preemption valid output for one cycle on the next edge. The pulse carries that entry's core and identifier, and the mark is cleared. On a tie for the highest count, the lowest index is taken.
- R9: With a nonzero epoch length L, every L-th edge after reset release produces a new waiting-cycle value: the saturated sum shifted right by one. The first such edge is edge L. An epoch length of zero disables halving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| threshold_i | input | TWC_W | Waiting-cycle threshold for acceleration |
| epoch_len_i | input | EPOCH_W | Halving interval in cycles, 0 disables |
| ws_vld_i | input | 1 | Wait-start event |
| ws_bid_i | input | BID_W | Identifier for wait-start |
| we_vld_i | input | 1 | Wait-end event |
| we_bid_i | input | BID_W | Identifier for wait-end |
| call_vld_i | input | 1 | Bottleneck call from a small core |
| call_bid_i | input | BID_W | Identifier being called |
| call_core_i | input | CORE_W | Calling small core |
| ret_vld_i | input | 1 | Bottleneck return |
| ret_bid_i | input | BID_W | Identifier returning |
| ait_vld_o | output | 1 | Acceleration index update valid |
| ait_core_o | output | CORE_W | Small core whose index is updated |
| ait_bid_o | output | BID_W | Identifier of the update |
| ait_accel_o | output | 1 | 1: send to large core, 0: run locally |
| ait_lcore_o | output | LC_W | Target large core |
| preempt_vld_o | output | 1 | Preemption pulse |
| preempt_core_o | output | CORE_W | Small core to preempt |
| preempt_bid_o | output | BID_W | Identifier to preempt |

## Verification
The assertions check several rules on every cycle:
- identifiers stay unique in the table;
- waiting-cycle counts only grow between halvings;
- waiter counts rise only on a wait-start hit;
- the ranking picks a true maximum, and the victim picker a free slot or a true minimum;
- a return or a preemption clears the running mark.

Other behaviour needs scenarios with exact expected values and is shown only by the bench:
- the arithmetic of the waiting-cycle sum under different waiter histories;
- the strict threshold comparison;
- saturation rather than wrap;
- floor-at-zero waiters;
- which identifier is evicted from a full table;
- the exact edge of the halving;
- whether preemption fires or is suppressed after a return.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

  // Waiting-cycle update: add waiters, clamp to cap, optionally halve.
  function automatic logic [31:0] twc_step(input logic [31:0] twc,
                                           input logic [31:0] waiters,
                                           input logic        halve,
                                           input logic [31:0] cap);
    logic [31:0] s;
    s = twc + waiters;
    if (s > cap) s = cap;
    if (halve) s = s >> 1;
    return s;
  endfunction

  // Waiter update: +1 on start, -1 on end, saturating at both ends.
  function automatic logic [31:0] waiter_step(input logic [31:0] w,
                                              input logic        inc,
                                              input logic        dec,
                                              input logic [31:0] cap);
    logic [31:0] r;
    r = w;
    if (inc && !dec && w != cap) r = w + 32'd1;
    if (dec && !inc && w != 32'd0) r = w - 32'd1;
    return r;
  endfunction

endpackage

// File: rtl/bwt_entry.sv
module bwt_entry
  import bwt_pkg::*;
#(
  parameter int BID_W  = 16,
  parameter int WAIT_W = 6,
  parameter int TWC_W  = 16,
  parameter int CORE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_i,
  input  logic              ws_vld_i,
  input  logic [BID_W-1:0]  ws_bid_i,
  input  logic              we_vld_i,
  input  logic [BID_W-1:0]  we_bid_i,
  input  logic              call_vld_i,
  input  logic [BID_W-1:0]  call_bid_i,
  input  logic [CORE_W-1:0] call_core_i,
  input  logic              call_local_i,
  input  logic              ret_vld_i,
  input  logic [BID_W-1:0]  ret_bid_i,
  input  logic              halve_i,
  input  logic              preempt_clr_i,
  output logic              valid_o,
  output logic [BID_W-1:0]  bid_o,
  output logic [TWC_W-1:0]  twc_o,
  output logic              running_o,
  output logic [CORE_W-1:0] run_core_o,
  output logic              ws_hit_o,
  output logic              call_hit_o
);
  localparam logic [31:0] WAIT_CAP = 32'((64'd1 << WAIT_W) - 64'd1);
  localparam logic [31:0] TWC_CAP  = 32'((64'd1 << TWC_W) - 64'd1);

  logic              valid_q, running_q;
  logic [BID_W-1:0]  bid_q;
  logic [WAIT_W-1:0] waiters_q;
  logic [TWC_W-1:0]  twc_q;
  logic [CORE_W-1:0] core_q;
  logic              we_hit, ret_hit;

  assign ws_hit_o   = valid_q && ws_vld_i   && (bid_q == ws_bid_i);
  assign we_hit     = valid_q && we_vld_i   && (bid_q == we_bid_i);
  assign call_hit_o = valid_q && call_vld_i && (bid_q == call_bid_i);
  assign ret_hit    = valid_q && ret_vld_i  && (bid_q == ret_bid_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      bid_q     <= '0;
      waiters_q <= '0;
      twc_q     <= '0;
      running_q <= 1'b0;
      core_q    <= '0;
    end else if (alloc_i) begin
      valid_q   <= 1'b1;
      bid_q     <= ws_bid_i;
      waiters_q <= WAIT_W'(1);
      twc_q     <= '0;
      running_q <= 1'b0;
      core_q    <= '0;
    end else if (valid_q) begin
      waiters_q <= WAIT_W'(waiter_step(32'(waiters_q), ws_hit_o, we_hit, WAIT_CAP));
      twc_q     <= TWC_W'(twc_step(32'(twc_q), 32'(waiters_q), halve_i, TWC_CAP));
      if (preempt_clr_i || ret_hit || (call_hit_o && !call_local_i)) begin
        running_q <= 1'b0;
      end else if (call_hit_o && call_local_i) begin
        running_q <= 1'b1;
        core_q    <= call_core_i;
      end
    end
  end

  assign valid_o    = valid_q;
  assign bid_o      = bid_q;
  assign twc_o      = twc_q;
  assign running_o  = running_q;
  assign run_core_o = core_q;

  // R3
  twc_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !alloc_i && !halve_i |=> twc_q >= $past(twc_q));

  // R4
  waiters_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !alloc_i && !ws_hit_o |=> waiters_q <= $past(waiters_q));

  // R7
  ret_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_hit |=> !running_q);

  // R8
  preempt_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_clr_i |=> !running_q);

endmodule

// File: rtl/bwt_rank.sv
module bwt_rank #(
  parameter int ENTRIES = 32,
  parameter int TWC_W   = 16,
  parameter int IDX_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [TWC_W-1:0]   twc_i [ENTRIES],
  output logic [IDX_W-1:0]   top_idx_o,
  output logic               top_vld_o,
  output logic [IDX_W-1:0]   victim_idx_o
);
  logic [TWC_W-1:0] best, low;
  logic             have_free, seen;

  // Highest count; strict compare keeps the lowest index on ties.
  always_comb begin
    top_idx_o = '0;
    top_vld_o = 1'b0;
    best      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (valid_i[i] && (!top_vld_o || twc_i[i] > best)) begin
        top_vld_o = 1'b1;
        best      = twc_i[i];
        top_idx_o = IDX_W'(i);
      end
    end
  end

  // Victim: first free slot, else smallest count (lowest index on ties).
  always_comb begin
    victim_idx_o = '0;
    have_free    = 1'b0;
    seen         = 1'b0;
    low          = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!valid_i[i] && !have_free) begin
        have_free    = 1'b1;
        victim_idx_o = IDX_W'(i);
      end else if (valid_i[i] && !have_free && (!seen || twc_i[i] < low)) begin
        seen         = 1'b1;
        low          = twc_i[i];
        victim_idx_o = IDX_W'(i);
      end
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_chk
    // R8
    top_is_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i[g] |-> top_vld_o && (twc_i[top_idx_o] >= twc_i[g]));
    // R5
    victim_free_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i[g] |-> !valid_i[victim_idx_o]);
    // R5
    victim_is_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&valid_i) |-> twc_i[victim_idx_o] <= twc_i[g]);
  end

endmodule

// File: rtl/bottleneck_wait_table.sv
module bottleneck_wait_table
  import bwt_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int BID_W   = 16,
  parameter int WAIT_W  = 6,
  parameter int TWC_W   = 16,
  parameter int CORE_W  = 5,
  parameter int N_LARGE = 2,
  parameter int EPOCH_W = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int LC_W   = (N_LARGE > 1) ? $clog2(N_LARGE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [TWC_W-1:0]   threshold_i,
  input  logic [EPOCH_W-1:0] epoch_len_i,
  input  logic               ws_vld_i,
  input  logic [BID_W-1:0]   ws_bid_i,
  input  logic               we_vld_i,
  input  logic [BID_W-1:0]   we_bid_i,
  input  logic               call_vld_i,
  input  logic [BID_W-1:0]   call_bid_i,
  input  logic [CORE_W-1:0]  call_core_i,
  input  logic               ret_vld_i,
  input  logic [BID_W-1:0]   ret_bid_i,
  output logic               ait_vld_o,
  output logic [CORE_W-1:0]  ait_core_o,
  output logic [BID_W-1:0]   ait_bid_o,
  output logic               ait_accel_o,
  output logic [LC_W-1:0]    ait_lcore_o,
  output logic               preempt_vld_o,
  output logic [CORE_W-1:0]  preempt_core_o,
  output logic [BID_W-1:0]   preempt_bid_o
);
  logic [ENTRIES-1:0] valid_vec, running_vec, ws_hit_vec, call_hit_vec;
  logic [ENTRIES-1:0] alloc_vec, preempt_clr_vec;
  logic [BID_W-1:0]   bid_arr  [ENTRIES];
  logic [TWC_W-1:0]   twc_arr  [ENTRIES];
  logic [CORE_W-1:0]  core_arr [ENTRIES];
  logic [IDX_W-1:0]   top_idx, victim_idx;
  logic               top_vld;

  // Named internal events
  logic               alloc_ev, call_hit_ev, call_accel_ev, preempt_ev, halve_ev;
  logic [TWC_W-1:0]   call_twc;
  logic [EPOCH_W-1:0] epoch_q;
  logic [31:0]        call_bid_ext;

  assign alloc_ev = ws_vld_i && !(|ws_hit_vec);

  always_comb begin
    call_twc = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (call_hit_vec[i]) call_twc = call_twc | twc_arr[i];
  end
  assign call_hit_ev   = |call_hit_vec;
  assign call_accel_ev = call_hit_ev && (call_twc > threshold_i);

  assign preempt_ev = top_vld && running_vec[top_idx] && (twc_arr[top_idx] != '0);

  assign halve_ev = (epoch_len_i != '0) && (epoch_q >= epoch_len_i - EPOCH_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)                              epoch_q <= '0;
    else if (halve_ev || epoch_len_i == '0) epoch_q <= '0;
    else                                     epoch_q <= epoch_q + EPOCH_W'(1);
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign alloc_vec[g]       = alloc_ev && (victim_idx == IDX_W'(g));
    assign preempt_clr_vec[g] = preempt_ev && (top_idx == IDX_W'(g));

    bwt_entry #(
      .BID_W(BID_W), .WAIT_W(WAIT_W), .TWC_W(TWC_W), .CORE_W(CORE_W)
    ) u_ent (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_i      (alloc_vec[g]),
      .ws_vld_i     (ws_vld_i),
      .ws_bid_i     (ws_bid_i),
      .we_vld_i     (we_vld_i),
      .we_bid_i     (we_bid_i),
      .call_vld_i   (call_vld_i),
      .call_bid_i   (call_bid_i),
      .call_core_i  (call_core_i),
      .call_local_i (!call_accel_ev),
      .ret_vld_i    (ret_vld_i),
      .ret_bid_i    (ret_bid_i),
      .halve_i      (halve_ev),
      .preempt_clr_i(preempt_clr_vec[g]),
      .valid_o      (valid_vec[g]),
      .bid_o        (bid_arr[g]),
      .twc_o        (twc_arr[g]),
      .running_o    (running_vec[g]),
      .run_core_o   (core_arr[g]),
      .ws_hit_o     (ws_hit_vec[g]),
      .call_hit_o   (call_hit_vec[g])
    );
  end

  bwt_rank #(.ENTRIES(ENTRIES), .TWC_W(TWC_W), .IDX_W(IDX_W)) u_rank (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (valid_vec),
    .twc_i       (twc_arr),
    .top_idx_o   (top_idx),
    .top_vld_o   (top_vld),
    .victim_idx_o(victim_idx)
  );

  assign call_bid_ext = 32'(call_bid_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ait_vld_o      <= 1'b0;
      ait_core_o     <= '0;
      ait_bid_o      <= '0;
      ait_accel_o    <= 1'b0;
      ait_lcore_o    <= '0;
      preempt_vld_o  <= 1'b0;
      preempt_core_o <= '0;
      preempt_bid_o  <= '0;
    end else begin
      ait_vld_o   <= call_vld_i;
      ait_accel_o <= call_vld_i && call_accel_ev;
      if (call_vld_i) begin
        ait_core_o  <= call_core_i;
        ait_bid_o   <= call_bid_i;
        ait_lcore_o <= LC_W'(call_bid_ext % 32'(N_LARGE));
      end
      preempt_vld_o <= preempt_ev;
      if (preempt_ev) begin
        preempt_core_o <= core_arr[top_idx];
        preempt_bid_o  <= bid_arr[top_idx];
      end
    end
  end

  // R2
  ws_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ws_hit_vec));

  // R6
  call_single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(call_hit_vec));

  // R6
  ait_follows_call_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ait_vld_o |-> $past(call_vld_i));

  // R6
  accel_needs_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ait_accel_o |-> ait_vld_o);

endmodule

// File: tb/tb_bottleneck_wait_table.sv
module tb_bottleneck_wait_table;
  localparam int ENT = 4, BW = 16, WW = 6, TW = 10, CW = 5, NL = 2, EW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [TW-1:0] threshold = '0;
  logic [EW-1:0] epoch_len = '0;
  logic          ws_vld = 1'b0, we_vld = 1'b0, call_vld = 1'b0, ret_vld = 1'b0;
  logic [BW-1:0] ws_bid = '0, we_bid = '0, call_bid = '0, ret_bid = '0;
  logic [CW-1:0] call_core = '0;
  logic          ait_vld_o, ait_accel_o, preempt_vld_o;
  logic [CW-1:0] ait_core_o, preempt_core_o;
  logic [BW-1:0] ait_bid_o, preempt_bid_o;
  logic [0:0]    ait_lcore_o;

  int  errors = 0;
  int  total  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  bottleneck_wait_table #(
    .ENTRIES(ENT), .BID_W(BW), .WAIT_W(WW), .TWC_W(TW),
    .CORE_W(CW), .N_LARGE(NL), .EPOCH_W(EW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .threshold_i(threshold), .epoch_len_i(epoch_len),
    .ws_vld_i(ws_vld), .ws_bid_i(ws_bid), .we_vld_i(we_vld), .we_bid_i(we_bid),
    .call_vld_i(call_vld), .call_bid_i(call_bid), .call_core_i(call_core),
    .ret_vld_i(ret_vld), .ret_bid_i(ret_bid),
    .ait_vld_o(ait_vld_o), .ait_core_o(ait_core_o), .ait_bid_o(ait_bid_o),
    .ait_accel_o(ait_accel_o), .ait_lcore_o(ait_lcore_o),
    .preempt_vld_o(preempt_vld_o), .preempt_core_o(preempt_core_o),
    .preempt_bid_o(preempt_bid_o)
  );

  // Columns: bid, waiters started, idle edges, threshold, expected accel.
  // Expected count at the call edge = n*(n-1)/2 + n*k.
  localparam int VEC [7][5] = '{
    '{3, 1, 10,  9, 1},
    '{4, 1, 10, 10, 0},
    '{5, 3,  4, 14, 1},
    '{6, 3,  4, 15, 0},
    '{7, 4,  0,  5, 1},
    '{8, 2, 20, 41, 0},
    '{9, 5,  2,  0, 1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic reset_dut(input int elen);
    @(negedge clk);
    rst_n = 1'b0;
    ws_vld = 1'b0; we_vld = 1'b0; call_vld = 1'b0; ret_vld = 1'b0;
    epoch_len = EW'(elen);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic ws(input int bid);
    ws_vld = 1'b1; ws_bid = BW'(bid);
    @(negedge clk);
    ws_vld = 1'b0;
  endtask

  task automatic we(input int bid);
    we_vld = 1'b1; we_bid = BW'(bid);
    @(negedge clk);
    we_vld = 1'b0;
  endtask

  task automatic ret(input int bid);
    ret_vld = 1'b1; ret_bid = BW'(bid);
    @(negedge clk);
    ret_vld = 1'b0;
  endtask

  task automatic do_call(input int bid, input int core, input int thr, input int exp,
                         input string req);
    call_vld = 1'b1; call_bid = BW'(bid); call_core = CW'(core); threshold = TW'(thr);
    @(negedge clk);
    call_vld = 1'b0;
    chk(req, 32'(ait_vld_o), 32'd1);
    chk(req, 32'(ait_accel_o), 32'(exp));
    chk(req, 32'(ait_core_o), 32'(core));
    chk(req, 32'(ait_bid_o), 32'(bid));
    chk(req, 32'(ait_lcore_o), 32'(bid % NL));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, total);
      $finish;
    end
  end

  initial begin
    int pcnt;

    // R1: empty after reset, quiet outputs, call is answered locally
    reset_dut(0);
    chk("R1", 32'(ait_vld_o), 32'd0);
    chk("R1", 32'(preempt_vld_o), 32'd0);
    do_call(3, 1, 0, 0, "R1");

    // R2 R6: allocation, waiter increments, threshold decision
    for (int r = 0; r < 7; r++) begin
      reset_dut(0);
      for (int n = 0; n < VEC[r][1]; n++) ws(VEC[r][0]);
      repeat (VEC[r][2]) @(negedge clk);
      do_call(VEC[r][0], r + 1, VEC[r][3], VEC[r][4], "R6");
    end

    // R3: saturation instead of wrap (1100 cycles, cap 1023)
    reset_dut(0);
    ws(20);
    repeat (1100) @(negedge clk);
    do_call(20, 2, 1022, 1, "R3");
    do_call(20, 2, 1023, 0, "R3");

    // R4: extra wait-end does not underflow; count frozen at 4
    reset_dut(0);
    ws(30); ws(30); we(30); we(30); we(30);
    repeat (10) @(negedge clk);
    do_call(30, 4, 3, 1, "R4");
    do_call(30, 4, 4, 0, "R4");

    // R5: counts become 7,5,3,1; new id evicts the smallest
    reset_dut(0);
    ws(1); ws(2); ws(3); ws(4);
    we(4); we(3); we(2); we(1);
    ws(5);
    do_call(4, 1, 0, 0, "R5");
    do_call(1, 1, 6, 1, "R5");
    do_call(3, 1, 2, 1, "R5");
    do_call(2, 1, 4, 1, "R5");

    // R8: local call on the only waited-on entry triggers preemption
    reset_dut(0);
    ws(9);
    do_call(9, 5, 1000, 0, "R8");
    chk("R8", 32'(preempt_vld_o), 32'd0);
    @(negedge clk);
    chk("R8", 32'(preempt_vld_o), 32'd1);
    chk("R8", 32'(preempt_core_o), 32'd5);
    chk("R8", 32'(preempt_bid_o), 32'd9);
    @(negedge clk);
    chk("R8", 32'(preempt_vld_o), 32'd0);

    // R7: return clears the running mark; no preemption once it becomes top
    reset_dut(0);
    ws(8); ws(8); ws(7);
    do_call(7, 3, 1000, 0, "R7");
    pcnt = 0;
    if (preempt_vld_o) pcnt++;
    ret(7);
    if (preempt_vld_o) pcnt++;
    for (int i = 0; i < 4; i++) begin
      ws(7);
      if (preempt_vld_o) pcnt++;
    end
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (preempt_vld_o) pcnt++;
    end
    chk("R7", 32'(pcnt), 32'd0);

    // R9: epoch 8 halves at edges 8 and 16; count 5 at edge 17, 6 at edge 18
    reset_dut(8);
    ws(11);
    repeat (15) @(negedge clk);
    do_call(11, 2, 5, 0, "R9");
    do_call(11, 2, 4, 1, "R9");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  end

endmodule